// File: doc/BRIEF.md
# Fractional-Prescaler Baud Tick Generator

This block makes the timing pulses for a serial port from one fixed reference clock. The reference goes through three dividers in turn. The first is a prescaler whose ratio is a fixed-point value in steps of one eighth. The second is a 16-bit integer divisor. The third is an oversampling divider that can be set from 4 to 16. The block emits two single-cycle pulses. The oversample tick goes to the receiver's sampling logic. The bit tick marks each bit period at the final baud rate.

A simple write port programs the block. The port holds the two halves of the prescaler, the oversampling ratio, the two halves of the divisor, an extended-mode enable and a prescaler enable. The prescaler can only be changed while extended mode is on. Writing its low byte also clears its top bit, so software must write the low byte before the high bit. Any write restarts all three dividers, so the first bit period after reprogramming already has the new length.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the prescaler raw value is 271 (33.875), the prescaler is bypassed, extended mode is off, the divisor is 1 and the oversampling ratio is 16. So the oversample tick is high every cycle, and the bit tick is first high in the 16th cycle, counting the cycle in which reset is released as the first.
- R2: Write addresses on `wr_addr_i`: 0 prescaler low byte, 1 prescaler high bit (data bit 0), 2 oversampling ratio (data bits 4:0), 3 divisor low byte, 4 divisor high byte, 5 extended-mode enable (data bit 0), 6 prescaler enable (data bit 0). The three stages are cascaded, so the bit tick rate is the reference rate × 8 / raw / divisor / ratio.
- R3: With the prescaler enabled, an eighth-step accumulator starts at 0 after a restart. Each cycle it adds 8. When the sum reaches the raw value it subtracts the raw value and emits a prescaler pulse. So n cycles after a restart hold exactly floor(8n/raw) pulses. A raw value below 8 acts as 8.
- R4: With the prescaler enable bit clear, the prescaler divides by 1 whatever raw value is stored.
- R5: Writes to addresses 0 and 1 leave the prescaler unchanged while extended mode is off.
- R6: A write to address 0 in extended mode sets the top prescaler bit to 0.
- R7: The divisor is {high byte, low byte}, and 0 acts as 1. The oversample tick fires on every divisor-th prescaler pulse, the first one a full divisor count after a restart.
- R8: Oversampling ratio codes: 0 or above 16 give 16, 1 to 3 give 4, and 4 to 16 give themselves. The bit tick fires together with every ratio-th oversample tick and never without one.
- R9: Any write restarts all dividers on the next rising edge. In the cycle between the write edge and that edge, both ticks stay low. After the restart the accumulator is 0 and the count begins with the newly written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| os_tick_o | output | 1 | Oversample tick, one cycle wide |
| bit_tick_o | output | 1 | Bit tick, one cycle wide |

## Verification
A write lands in the registers on the edge that samples it. The cycle after that edge is the restart cycle, in which both ticks must be low. The divider count begins on the following edge, and the ticks are combinational from divider state. The reference model in the bench follows the same edge-by-edge timing. It is compared with both outputs at every falling edge, so all results are checked half a cycle after the edge that produced them. The directed rate checks start counting at the first falling edge after the restart edge. They compare pulse counts over a fixed window with floor(8n/raw), the divisor and the ratio.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  typedef enum logic [2:0] {
    REG_PRE_LO = 3'd0,
    REG_PRE_HI = 3'd1,
    REG_OVS    = 3'd2,
    REG_DIV_LO = 3'd3,
    REG_DIV_HI = 3'd4,
    REG_MODE   = 3'd5,
    REG_CTRL   = 3'd6
  } reg_addr_e;

  localparam int PRE_STEP  = 8;    // one eighth per unit
  localparam int PRE_RESET = 271;  // 33.875
  localparam int OVS_MIN   = 4;
  localparam int OVS_MAX   = 16;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import frac_baud_pkg::*;
#(
  parameter int PRE_W  = 9,
  parameter int DIV_W  = 16,
  parameter int OVS_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PRE_W-1:0]  pre_raw_o,
  output logic              pre_en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [OVS_W-1:0]  ovs_o,
  output logic              reload_o
);
  localparam int PRE_HI_W = PRE_W - DATA_W;
  localparam int DIV_HI_W = DIV_W - DATA_W;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [OVS_W-1:0] ovs_q;
  logic             enh_q, pre_en_q, reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= PRE_W'(PRE_RESET);
      div_q    <= DIV_W'(1);
      ovs_q    <= '0;
      enh_q    <= 1'b0;
      pre_en_q <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= wr_en_i;
      if (wr_en_i) begin
        case (reg_addr_e'(wr_addr_i))
          REG_PRE_LO: if (enh_q) pre_q <= PRE_W'(wr_data_i);  // clears top bits
          REG_PRE_HI: if (enh_q) pre_q[PRE_W-1:DATA_W] <= wr_data_i[PRE_HI_W-1:0];
          REG_OVS:    ovs_q <= wr_data_i[OVS_W-1:0];
          REG_DIV_LO: div_q[DATA_W-1:0] <= wr_data_i;
          REG_DIV_HI: div_q[DIV_W-1:DATA_W] <= wr_data_i[DIV_HI_W-1:0];
          REG_MODE:   enh_q <= wr_data_i[0];
          REG_CTRL:   pre_en_q <= wr_data_i[0];
          default: ;
        endcase
      end
    end
  end

  assign pre_raw_o = pre_q;
  assign pre_en_o  = pre_en_q;
  assign div_o     = div_q;
  assign ovs_o     = ovs_q;
  assign reload_o  = reload_q;

  // R5
  pre_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !enh_q && (wr_addr_i == REG_PRE_LO || wr_addr_i == REG_PRE_HI))
    |=> $stable(pre_q));

  // R6
  pre_hi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && enh_q && wr_addr_i == REG_PRE_LO) |=> (pre_q[PRE_W-1:DATA_W] == '0));
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import frac_baud_pkg::*;
#(
  parameter int PRE_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             en_i,
  input  logic [PRE_W-1:0] raw_i,
  output logic             stb_o
);
  localparam int ACC_W = PRE_W + 1;

  logic [ACC_W-1:0] acc_q, sum;
  logic [PRE_W-1:0] r_eff;
  logic             hit;

  always_comb begin
    r_eff = (!en_i || raw_i < PRE_W'(PRE_STEP)) ? PRE_W'(PRE_STEP) : raw_i;
    sum   = acc_q + ACC_W'(PRE_STEP);
    hit   = sum >= ACC_W'(r_eff);
  end

  assign stb_o = hit && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (reload_i) acc_q <= '0;
    else if (hit)      acc_q <= sum - ACC_W'(r_eff);
    else               acc_q <= sum;
  end

  // R9
  acc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (acc_q == '0));

  // R3
  acc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !hit) |=> (acc_q == $past(acc_q) + ACC_W'(PRE_STEP)));
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int W         = 16,
  parameter int RESET_CNT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reload_i,
  input  logic         stb_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = stb_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(RESET_CNT);
    else if (reload_i)      cnt_q <= ratio_i - W'(1);
    else if (stb_i) begin
      if (cnt_q == '0)      cnt_q <= ratio_i - W'(1);
      else                  cnt_q <= cnt_q - W'(1);
    end
  end

  // R9
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_q == $past(ratio_i) - W'(1)));

  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !stb_i) |=> $stable(cnt_q));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int PRE_W  = 9,
  parameter int DIV_W  = 16,
  parameter int OVS_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              os_tick_o,
  output logic              bit_tick_o
);
  logic [PRE_W-1:0] pre_raw;
  logic [DIV_W-1:0] div_raw, div_eff;
  logic [OVS_W-1:0] ovs_raw, ovs_eff;
  logic             pre_en, reload, pre_stb;

  baud_regs #(.PRE_W(PRE_W), .DIV_W(DIV_W), .OVS_W(OVS_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .pre_raw_o(pre_raw), .pre_en_o(pre_en), .div_o(div_raw),
    .ovs_o(ovs_raw), .reload_o(reload)
  );

  always_comb begin
    div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
    if (ovs_raw == '0 || ovs_raw > OVS_W'(OVS_MAX)) ovs_eff = OVS_W'(OVS_MAX);
    else if (ovs_raw < OVS_W'(OVS_MIN))            ovs_eff = OVS_W'(OVS_MIN);
    else                                            ovs_eff = ovs_raw;
  end

  frac_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .reload_i(reload), .en_i(pre_en), .raw_i(pre_raw), .stb_o(pre_stb)
  );

  tick_divider #(.W(DIV_W), .RESET_CNT(0)) u_div (
    .clk_i, .rst_ni, .reload_i(reload), .stb_i(pre_stb), .ratio_i(div_eff), .tick_o(os_tick_o)
  );

  tick_divider #(.W(OVS_W), .RESET_CNT(OVS_MAX - 1)) u_ovs (
    .clk_i, .rst_ni, .reload_i(reload), .stb_i(os_tick_o), .ratio_i(ovs_eff), .tick_o(bit_tick_o)
  );

  // R8
  bit_in_os_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);

  // R9
  quiet_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> (!os_tick_o && !bit_tick_o));
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       os_tick_o, bit_tick_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  frac_baud_gen u_frac_baud_gen (.*);

  always #2.5 clk_i = ~clk_i;

  // behavioural reference
  int m_pre, m_ovs, m_div, m_acc, m_dc, m_oc;
  bit m_enh, m_pen, m_pend;

  function automatic int eff_r();
    if (!m_pen || m_pre < 8) return 8;
    return m_pre;
  endfunction
  function automatic int eff_div();
    return (m_div == 0) ? 1 : m_div;
  endfunction
  function automatic int eff_ovs();
    if (m_ovs == 0 || m_ovs > 16) return 16;
    if (m_ovs < 4) return 4;
    return m_ovs;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 271; m_ovs = 0; m_div = 1; m_enh = 0; m_pen = 0;
      m_acc = 0; m_dc = 0; m_oc = 15; m_pend = 0;
    end else begin
      if (m_pend) begin
        m_acc = 0; m_dc = eff_div() - 1; m_oc = eff_ovs() - 1;
      end else begin
        automatic int  r  = eff_r();
        automatic bit  p  = (m_acc + 8 >= r);
        automatic bit  os = p && (m_dc == 0);
        m_acc = p ? m_acc + 8 - r : m_acc + 8;
        if (p)  m_dc = (m_dc == 0) ? eff_div() - 1 : m_dc - 1;
        if (os) m_oc = (m_oc == 0) ? eff_ovs() - 1 : m_oc - 1;
      end
      m_pend = wr_en_i;
      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: if (m_enh) m_pre = int'(wr_data_i);
          3'd1: if (m_enh) m_pre = (m_pre & 255) | (int'(wr_data_i[0]) << 8);
          3'd2: m_ovs = int'(wr_data_i[4:0]);
          3'd3: m_div = (m_div & 16'hff00) | int'(wr_data_i);
          3'd4: m_div = (m_div & 255) | (int'(wr_data_i) << 8);
          3'd5: m_enh = wr_data_i[0];
          3'd6: m_pen = wr_data_i[0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model (R9 timing, R3/R7/R8 counting)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      automatic bit e_os  = !m_pend && (m_acc + 8 >= eff_r()) && (m_dc == 0);
      automatic bit e_bit = e_os && (m_oc == 0);
      tests++;
      if (os_tick_o !== e_os || bit_tick_o !== e_bit) begin
        fails++;
        $display("FAIL R9 model: os/bit = %b%b, expected %b%b at %0t",
                 os_tick_o, bit_tick_o, e_os, e_bit, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic count(input int n, output int os_n, output int bit_n);
    os_n = 0; bit_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      os_n += int'(os_tick_o);
      bit_n += int'(bit_tick_o);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, expected completion");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int o, b, first_bit, os_sum;
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: release cycle is cycle 1; samples below start at cycle 2
    first_bit = 0; os_sum = 0;
    for (int i = 2; i <= 40; i++) begin
      @(negedge clk_i);
      os_sum += int'(os_tick_o);
      if (bit_tick_o && first_bit == 0) first_bit = i;
    end
    check("R1 first bit tick cycle", first_bit, 16);
    check("R1 os ticks every cycle", os_sum, 39);

    // R5: prescaler writes ignored outside extended mode
    wr(3'd6, 8'h01);
    wr(3'd0, 8'd16);
    wr(3'd1, 8'd0);
    count(271, o, b);
    check("R5 locked prescaler os count", o, 8);

    // R6: high bit set, then low write clears it -> raw 16
    wr(3'd5, 8'h01);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'd16);
    count(64, o, b);
    check("R6 low write clears high bit", o, 32);

    // R3: fractional 2.5
    wr(3'd0, 8'd20);
    count(40, o, b);
    check("R3 raw 20 os count", o, 16);
    wr(3'd0, 8'd3);
    count(40, o, b);
    check("R3 raw below 8 acts as 8", o, 40);

    // R4: bypass
    wr(3'd0, 8'd20);
    wr(3'd6, 8'h00);
    count(40, o, b);
    check("R4 bypass ignores raw", o, 40);

    // R7: divisor
    wr(3'd3, 8'd5);
    count(100, o, b);
    check("R7 divisor 5", o, 20);
    wr(3'd3, 8'd0);
    count(100, o, b);
    check("R7 divisor 0 acts as 1", o, 100);
    wr(3'd4, 8'd1);
    count(600, o, b);
    check("R7 divisor 256", o, 2);

    // R9: quiet restart cycle, then running again
    wr(3'd4, 8'd0);
    tests++;
    if (os_tick_o !== 1'b0) begin
      fails++;
      $display("FAIL R9 restart cycle: os %b, expected 0", os_tick_o);
    end
    wr(3'd3, 8'd1);
    @(negedge clk_i);
    check("R9 first tick after restart", int'(os_tick_o), 1);

    // R8: oversampling codes
    wr(3'd2, 8'd4);
    count(100, o, b);
    check("R8 ratio 4", b, 25);
    wr(3'd2, 8'd0);
    count(100, o, b);
    check("R8 ratio code 0", b, 6);
    wr(3'd2, 8'd2);
    count(100, o, b);
    check("R8 ratio code 2", b, 25);
    wr(3'd2, 8'd20);
    count(100, o, b);
    check("R8 ratio code 20", b, 6);
    wr(3'd2, 8'd7);
    count(100, o, b);
    check("R8 ratio 7", b, 14);

    // R2: full cascade 2.5 x 3 x 5
    wr(3'd6, 8'h01);
    wr(3'd0, 8'd20);
    wr(3'd3, 8'd3);
    wr(3'd2, 8'd5);
    count(150, o, b);
    check("R2 cascade os count", o, 20);
    check("R2 cascade bit count", b, 4);

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule